// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts video lines for a cartridge bank controller. The video chip's address bit 12 rises once per line while it fetches from the upper pattern table. The block treats each such rise as a line tick, but only when the line had been quiet long enough before it. Quiet means it stayed low while the CPU clock phase M2 fell several times. This filter rejects the short A12 pulses that occur inside one line.

Each accepted tick either reloads a down counter from a latch or decrements it. The reload happens when the counter is zero or when software has asked for one. When the counter then holds zero and interrupts are enabled, a pending flag is set and the active-low interrupt line stays low until software clears it.

Software reaches the block through CPU writes decoded from three address bits. A14 high selects the counter group. A13 picks the reload pair or the enable pair. A0 picks the even or odd register of the pair. The data value matters only for the latch write. All inputs are sampled on the block's own clock, and the asynchronous reset is released synchronously.

Top module: `scanline_irq`

## Requirements
- R1: After reset the interrupt line is high, interrupts are disabled, the counter and the latch are zero and no reload is requested.
- R2: A low-to-high change of `a12` counts as a tick only if `a12` was sampled low at no fewer than 3 (`FILTER_EDGES`) high-to-low changes of `m2` since it was last sampled high. A rise with fewer such changes is ignored.
- R3: A write with A14=1, A13=0, A0=0 stores `cpu_d` as the reload latch.
- R4: A write with A14=1, A13=0, A0=1 clears the counter at once and requests a reload, whatever the data.
- R5: On a tick, if the counter is zero or a reload is requested, the latch is copied into the counter and the request is cleared. With a latch of zero this gives an interrupt on every tick.
- R6: On a tick with a nonzero counter and no request, the counter decrements by one. With no tick and no clearing write it holds.
- R7: If the counter value left by a tick is zero and interrupts are enabled, the pending flag is set. `irq_n` goes low one clock after the tick's sampling edge and stays low until acknowledged.
- R8: A write with A14=1, A13=1, A0=1 enables interrupts.
- R9: A write with A14=1, A13=1, A0=0 disables interrupts and clears the pending flag, so `irq_n` returns high.
- R10: A write with A14=0, or any cycle with `wr_en` low, changes no state.
- R11: When a write and a tick fall in the same cycle, the tick is evaluated on the state from before that cycle. The write then overrides the fields it touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m2 | input | 1 | CPU clock phase, sampled |
| a12 | input | 1 | Video address bit 12, sampled |
| wr_en | input | 1 | One-cycle CPU write strobe |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_a0 | input | 1 | CPU address bit 0 |
| cpu_d | input | 8 | CPU write data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Regular lines with three M2 falls before each A12 rise show that the counter loads and then decrements. Lines with only two falls show that the filter rejects a short low period; an unfiltered counter would raise the interrupt early. Writes aimed at the counter registers with A14 low, and writes that coincide with a tick, separate correct decode and ordering from decode that ignores A14 or lets the write act first. A long seeded random run mixes M2 noise, A12 runs of varying length and random writes, and compares `irq_n` every cycle against a model built from the requirements.

// File: rtl/scl_pkg.sv
package scl_pkg;
  // One-cycle command pulses from the write decoder
  typedef struct packed {
    logic load_latch;
    logic req_reload;
    logic irq_off;
    logic irq_on;
  } scl_cmd_t;

  // {A13, A0} within the counter group
  typedef enum logic [1:0] {
    SEL_LATCH  = 2'b00,
    SEL_RELOAD = 2'b01,
    SEL_OFF    = 2'b10,
    SEL_ON     = 2'b11
  } scl_sel_e;
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/scl_edge_filter.sv
module scl_edge_filter #(
  parameter int FILTER_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m2,
  input  logic a12,
  output logic tick
);
  localparam int FW = $clog2(FILTER_EDGES + 1);
  localparam logic [FW-1:0] FMAX = FW'(FILTER_EDGES);

  logic          m2_q, a12_q;
  logic [FW-1:0] low_cnt, low_cnt_nx;
  logic          m2_fall, a12_rise;

  always_comb begin
    m2_fall  = m2_q & ~m2;
    a12_rise = ~a12_q & a12;
    tick     = a12_rise && (low_cnt == FMAX);
    low_cnt_nx = low_cnt;
    if (a12)                           low_cnt_nx = '0;
    else if (m2_fall && low_cnt != FMAX) low_cnt_nx = low_cnt + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m2_q    <= 1'b0;
      a12_q   <= 1'b1;
      low_cnt <= '0;
    end else begin
      m2_q    <= m2;
      a12_q   <= a12;
      low_cnt <= low_cnt_nx;
    end
  end

  // R2: a high A12 sample empties the quiet-time count
  p_clear_on_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a12 |=> (low_cnt == '0));

  // R2: the quiet-time count saturates while A12 stays low
  p_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt == FMAX && !a12) |=> (low_cnt == FMAX));
endmodule

// File: rtl/scl_reg_decode.sv
module scl_reg_decode
  import scl_pkg::*;
(
  input  logic     wr_en,
  input  logic     cpu_a14,
  input  logic     cpu_a13,
  input  logic     cpu_a0,
  output scl_cmd_t cmd
);
  scl_sel_e sel;

  always_comb begin
    sel = scl_sel_e'({cpu_a13, cpu_a0});
    cmd = '0;
    if (wr_en && cpu_a14) begin
      unique case (sel)
        SEL_LATCH:  cmd.load_latch = 1'b1;
        SEL_RELOAD: cmd.req_reload = 1'b1;
        SEL_OFF:    cmd.irq_off    = 1'b1;
        SEL_ON:     cmd.irq_on     = 1'b1;
        default:    cmd            = '0;
      endcase
    end
  end
endmodule

// File: rtl/scl_down_counter.sv
module scl_down_counter
  import scl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  scl_cmd_t         cmd,
  input  logic [CNT_W-1:0] wdata,
  output logic             irq_pend
);
  logic [CNT_W-1:0] cnt, cnt_nx, latch, latch_nx;
  logic             req, req_nx, en, en_nx, pend_nx;

  always_comb begin
    cnt_nx   = cnt;
    latch_nx = latch;
    req_nx   = req;
    en_nx    = en;
    pend_nx  = irq_pend;
    // tick evaluated on the state from before this cycle
    if (tick) begin
      if (cnt == '0 || req) begin
        cnt_nx = latch;
        req_nx = 1'b0;
      end else begin
        cnt_nx = cnt - CNT_W'(1);
      end
      if (cnt_nx == '0 && en) pend_nx = 1'b1;
    end
    // writes override what they touch
    if (cmd.load_latch) latch_nx = wdata;
    if (cmd.req_reload) begin
      cnt_nx = '0;
      req_nx = 1'b1;
    end
    if (cmd.irq_off) begin
      en_nx   = 1'b0;
      pend_nx = 1'b0;
    end
    if (cmd.irq_on) en_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      latch    <= '0;
      req      <= 1'b0;
      en       <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      latch    <= latch_nx;
      req      <= req_nx;
      en       <= en_nx;
      irq_pend <= pend_nx;
    end
  end

  // R5: reload path copies the latch held before the tick
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt == '0 || req) && !cmd.req_reload) |=> (cnt == $past(latch) && !req));

  // R6: decrement path
  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !req && !cmd.req_reload) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R6: no tick and no clear leaves the count alone
  p_hold_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cmd.req_reload) |=> $stable(cnt));

  // R4: clearing write empties the counter and arms a reload
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.req_reload |=> (cnt == '0 && req));

  // R7: pending holds until acknowledged
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !cmd.irq_off) |=> irq_pend);

  // R9: acknowledge drops the request
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.irq_off |=> (!irq_pend && !en));

  // R8: enable write
  p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.irq_on |=> en);
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq
  import scl_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int FILTER_EDGES = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m2,
  input  logic             a12,
  input  logic             wr_en,
  input  logic             cpu_a14,
  input  logic             cpu_a13,
  input  logic             cpu_a0,
  input  logic [CNT_W-1:0] cpu_d,
  output logic             irq_n
);
  logic     rst_sync_n;
  logic     tick;
  logic     irq_pend;
  scl_cmd_t cmd;

  scl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scl_edge_filter #(.FILTER_EDGES(FILTER_EDGES)) u_filt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .m2    (m2),
    .a12   (a12),
    .tick  (tick)
  );

  scl_reg_decode u_dec (
    .wr_en   (wr_en),
    .cpu_a14 (cpu_a14),
    .cpu_a13 (cpu_a13),
    .cpu_a0  (cpu_a0),
    .cmd     (cmd)
  );

  scl_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .cmd      (cmd),
    .wdata    (cpu_d),
    .irq_pend (irq_pend)
  );

  assign irq_n = ~irq_pend;

  // R10: writes outside the counter group never produce a command
  p_ignore_low_a14_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cpu_a14 || !wr_en) |-> (cmd == '0));

  // R7: the interrupt line falls only after a tick
  p_fall_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_n && !tick) |=> irq_n);
endmodule

// File: tb/scanline_irq_test.sv
module scanline_irq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       m2, a12, wr_en, cpu_a14, cpu_a13, cpu_a0;
  logic [7:0] cpu_d;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  bit       mm2, ma12, mreq, men, mpend;
  int       mlow;
  bit [7:0] mcnt, mlatch;

  always #5 clk = ~clk;

  scanline_irq uut (
    .clk(clk), .rst_n(rst_n), .m2(m2), .a12(a12), .wr_en(wr_en),
    .cpu_a14(cpu_a14), .cpu_a13(cpu_a13), .cpu_a0(cpu_a0),
    .cpu_d(cpu_d), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_irq_n();
    return !mpend;
  endfunction

  // model of one clock edge, built from the requirements
  task automatic model_edge(input bit im2, input bit ia12, input bit iw,
                            input bit x14, input bit x13, input bit x0, input bit [7:0] d);
    bit fall, tick;
    bit [7:0] nc;
    fall = mm2 && !im2;
    tick = !ma12 && ia12 && (mlow == 3);
    if (tick) begin
      if (mcnt == 0 || mreq) begin nc = mlatch; mreq = 0; end
      else nc = mcnt - 8'd1;
      mcnt = nc;
      if (nc == 0 && men) mpend = 1;
    end
    if (ia12) mlow = 0;
    else if (fall && mlow < 3) mlow = mlow + 1;
    if (iw && x14) begin
      case ({x13, x0})
        2'b00: mlatch = d;
        2'b01: begin mcnt = 0; mreq = 1; end
        2'b10: begin men = 0; mpend = 0; end
        default: men = 1;
      endcase
    end
    mm2 = im2;
    ma12 = ia12;
  endtask

  task automatic step(input bit im2, input bit ia12, input bit iw = 0,
                      input bit x14 = 0, input bit x13 = 0, input bit x0 = 0,
                      input bit [7:0] d = 0);
    @(negedge clk);
    m2 = im2; a12 = ia12; wr_en = iw;
    cpu_a14 = x14; cpu_a13 = x13; cpu_a0 = x0; cpu_d = d;
    @(posedge clk);
    model_edge(im2, ia12, iw, x14, x13, x0, d);
    #2;
  endtask

  task automatic wr(input bit x14, input bit x13, input bit x0, input bit [7:0] d);
    step(m2, a12, 1'b1, x14, x13, x0, d);
  endtask

  // one line: A12 low with n M2 falls, then A12 rises
  task automatic line(input int n);
    step(1'b1, 1'b0);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
    end
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m2 = 0; a12 = 0; wr_en = 0; cpu_a14 = 0; cpu_a13 = 0; cpu_a0 = 0; cpu_d = 0;
    mm2 = 0; ma12 = 0; mlow = 0; mcnt = 0; mlatch = 0; mreq = 0; men = 0; mpend = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    #2;
    check(irq_n == 1, "R1 reset irq_n", irq_n, 1);

    // R1: enabled with zero latch: first tick loads 0 -> interrupt
    wr(1, 1, 1, 8'h00);
    line(3);
    check(irq_n == 0, "R1 zero counter after reset reloads to 0", irq_n, 0);
    wr(1, 1, 0, 8'h5A);
    check(irq_n == 1, "R9 acknowledge", irq_n, 1);

    // R3 R4 R5 R6 R7: latch 2, clear, enable
    wr(1, 0, 0, 8'd2);
    wr(1, 0, 1, 8'hFF);
    wr(1, 1, 1, 8'h00);
    line(3);
    check(irq_n == 1, "R5 load 2 no irq", irq_n, 1);
    line(3);
    check(irq_n == 1, "R6 decrement to 1", irq_n, 1);
    line(3);
    check(irq_n == 0, "R7 reach zero irq", irq_n, 0);
    for (int i = 0; i < 6; i++) step(m2, a12);
    check(irq_n == 0, "R7 irq held", irq_n, 0);

    // R10: writes with A14 low or no strobe ignored
    wr(0, 1, 0, 8'h00);
    check(irq_n == 0, "R10 A14 low disable ignored", irq_n, 0);
    step(m2, a12, 1'b0, 1, 1, 0, 8'h00);
    check(irq_n == 0, "R10 no strobe ignored", irq_n, 0);
    wr(1, 1, 0, 8'h00);
    check(irq_n == 1, "R9 disable clears", irq_n, 1);
    line(3);
    check(irq_n == 1, "R9 disabled no irq at reload", irq_n, 1);

    // R2: filter. latch 1, clear, enable
    wr(1, 0, 0, 8'd1);
    wr(1, 0, 1, 8'h00);
    wr(1, 1, 1, 8'h00);
    line(3);
    check(irq_n == 1, "R2 load 1", irq_n, 1);
    line(2);
    check(irq_n == 1, "R2 two falls rejected", irq_n, 1);
    line(0);
    check(irq_n == 1, "R2 no falls rejected", irq_n, 1);
    line(5);
    check(irq_n == 0, "R2 five falls accepted", irq_n, 0);

    // R5: latch 0 gives an interrupt each tick
    wr(1, 0, 0, 8'd0);
    wr(1, 1, 0, 8'h00);
    wr(1, 1, 1, 8'h00);
    line(3);
    check(irq_n == 0, "R5 zero latch each line a", irq_n, 0);
    wr(1, 1, 0, 8'h00);
    wr(1, 1, 1, 8'h00);
    line(3);
    check(irq_n == 0, "R5 zero latch each line b", irq_n, 0);

    // R11: disable write in the tick's cycle wins
    wr(1, 1, 0, 8'h00);
    wr(1, 1, 1, 8'h00);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1, 1, 0, 8'h00);
    check(irq_n == 1, "R11 disable with tick", irq_n, 1);
    // R11: latch write with tick: tick uses old latch (0) then new latch 3 on request
    wr(1, 1, 1, 8'h00);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1, 0, 0, 8'd3);
    check(irq_n == 0, "R11 tick used old latch", irq_n, 0);
    wr(1, 1, 0, 8'h00);
    wr(1, 1, 1, 8'h00);
    line(3); // counter 0 -> loads 3
    check(irq_n == 1, "R11 new latch applied next", irq_n, 1);
    check(irq_n == exp_irq_n(), "R11 model agrees", irq_n, exp_irq_n());

    // random run
    begin
      bit ra12 = 0;
      for (int i = 0; i < 20000; i++) begin
        bit rm2, rw;
        if ($urandom % 8 == 0) ra12 = !ra12;
        rm2 = $urandom % 2;
        rw  = ($urandom % 16) == 0;
        step(rm2, ra12, rw, ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
             8'($urandom % 4));
        check(irq_n == exp_irq_n(), "R7 random model", irq_n, exp_irq_n());
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule